// File: doc/BRIEF.md
# SPI Access Error Status and Interrupt Summary

This block keeps the error record for a SPI-driven register access slave and the internal bus path behind it. Single-cycle event strobes arrive from the SPI framing and command decoder, from the read and write FIFOs, and from the internal access logic. Each detected fault sets its own sticky bit. The bit stays set until the host writes a 1 to its position in the status register.

The sticky bits fall into two groups: SPI-side faults and internal-side faults. Each group is reduced, after masking, to a summary flag, and the two summaries are ORed into one interrupt line. The block also compares live FIFO occupancy against two programmable thresholds. The results are two level flags that are not sticky.

Software reaches the block through a plain single-cycle register port. A write takes effect on the clock edge where `reg_wr_i` is high. Read data is combinational from `reg_addr_i`. No stream interface exists, so no back-pressure applies.

The register map is as follows. Address 0 is the status register. Address 1 is the mask register, where a 1 blocks that bit from its summary. Address 2 holds the thresholds: the write threshold in bits [7:0] and the read threshold in bits [15:8]. Address 3 is unused.

Top module: `spi_err_status`

## Requirements
- R1: After reset, every sticky bit and every mask bit is 0, both thresholds are 1, and all three interrupt outputs are low.
- R2: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event and a clear on the same bit in the same cycle leave the bit set. A bit becomes visible on the clock edge that samples its strobe.
- R3: When `xfer_end_i` is high and `xfer_bits_i` is not a multiple of 8, status bit 0 is set. A count that is a multiple of 8 sets nothing.
- R4: When `cmd_valid_i` is high with an opcode other than 8'h41 (read) or 8'h61 (write), status bit 1 is set.
- R5: When `seq_end_i` is high and `seq_done_words_i` is less than `seq_req_words_i`, an underflow bit is set: bit 2 for a write sequence (`seq_write_i`=1) and bit 4 for a read sequence.
- R6: When `seq_cont_i` is high and `seq_done_words_i` is at least `seq_req_words_i`, an overflow bit is set: bit 3 for a write sequence and bit 5 for a read sequence.
- R7: When `rf_fetch_i` is high and `rf_count_i` is 0, bit 9 is set if `rf_first_i` is 1, and bit 10 is set otherwise. A nonzero count sets neither bit.
- R8: When `wf_push_i` is high while `wf_count_i` equals the write FIFO depth, bit 8 is set.
- R9: The strobes for an internal error-log write, an internal write error and an internal read error set bits 11, 12 and 13 respectively.
- R10: `wr_avail_o` is high when (depth minus `wf_count_i`) is at least the write threshold. `rd_avail_o` is high when `rf_count_i` is at least the read threshold. Both flags can also be read as status bits 16 and 17.
- R11: `spi_err_irq_o` is the OR of unmasked bits 0–5 and 8–10. `int_err_irq_o` is the OR of unmasked bits 11–13. `irq_o` is the OR of the two. They can also be read as status bits 24, 25 and 26.
- R12: Reserved bits read 0 and ignore writes. Only mask bits 0–5 and 8–13 can be written. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_end_i | input | 1 | Chip select deasserted |
| xfer_bits_i | input | BITCNT_W | Bits clocked in the ending transfer |
| cmd_valid_i | input | 1 | Command byte decoded |
| cmd_opcode_i | input | 8 | Decoded command byte |
| seq_end_i | input | 1 | Access sequence ended |
| seq_cont_i | input | 1 | Continue clocks seen in sequence |
| seq_write_i | input | 1 | Current sequence is a write |
| seq_req_words_i | input | LEN_W | Words requested by length field |
| seq_done_words_i | input | LEN_W | Words moved so far |
| rf_fetch_i | input | 1 | Read data word needed from read FIFO |
| rf_first_i | input | 1 | Fetch is the first word of the sequence |
| rf_count_i | input | RCNT_W | Read FIFO occupancy |
| wf_push_i | input | 1 | Push into write/command FIFO |
| wf_count_i | input | WCNT_W | Write FIFO occupancy |
| int_rd_err_i | input | 1 | Internal read got error response |
| int_wr_err_i | input | 1 | Internal write got error response |
| err_log_wr_i | input | 1 | Internal error log entry written |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| wr_avail_o | output | 1 | Write FIFO free space at or above threshold |
| rd_avail_o | output | 1 | Read FIFO fill at or above threshold |
| spi_err_irq_o | output | 1 | Unmasked SPI-side error present |
| int_err_irq_o | output | 1 | Unmasked internal error present |
| irq_o | output | 1 | Combined interrupt |

## Verification
Some properties are asserted on every cycle. A set bit holds until it is cleared. A strobed bit always lands, even when a clear arrives with it. A clear without a set empties the bit. No bit appears without a strobe. The two read-FIFO faults are never raised together. A clean status never drives an interrupt.

Other behaviour only the bench scenarios can show. These are the exact decode of each fault condition and its boundary (a multiple of 8 bits, a count equal to the request, a FIFO exactly full, a first versus a later fetch). They also cover the threshold comparisons, mask routing into the right summary, and the read-zero behaviour of reserved positions.

// File: rtl/spi_err_pkg.sv
package spi_err_pkg;
  localparam int STICKY_W   = 14;
  localparam int B_XFER_END = 0;
  localparam int B_BAD_CMD  = 1;
  localparam int B_WR_UNDER = 2;
  localparam int B_WR_OVER  = 3;
  localparam int B_RD_UNDER = 4;
  localparam int B_RD_OVER  = 5;
  localparam int B_WF_OVF   = 8;
  localparam int B_RF_EMPTY = 9;
  localparam int B_RF_UNDER = 10;
  localparam int B_LOG_WR   = 11;
  localparam int B_INT_WR   = 12;
  localparam int B_INT_RD   = 13;
  localparam int B_WR_AVAIL = 16;
  localparam int B_RD_AVAIL = 17;
  localparam int B_SPI_SUM  = 24;
  localparam int B_INT_SUM  = 25;
  localparam int B_IRQ      = 26;

  localparam logic [STICKY_W-1:0] SPI_GRP   = 14'h073F;
  localparam logic [STICKY_W-1:0] INT_GRP   = 14'h3800;
  localparam logic [STICKY_W-1:0] VALID_MSK = SPI_GRP | INT_GRP;

  typedef enum logic [1:0] {
    A_STATUS = 2'd0,
    A_MASK   = 2'd1,
    A_THRESH = 2'd2,
    A_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/spi_err_detect.sv
module spi_err_detect
  import spi_err_pkg::*;
#(
  parameter int BITCNT_W = 16,
  parameter int LEN_W    = 8,
  parameter int WF_DEPTH = 16,
  parameter int WCNT_W   = 5,
  parameter int RCNT_W   = 5,
  parameter logic [7:0] OPC_RD = 8'h41,
  parameter logic [7:0] OPC_WR = 8'h61
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer_end_i,
  input  logic [BITCNT_W-1:0] xfer_bits_i,
  input  logic                cmd_valid_i,
  input  logic [7:0]          cmd_opcode_i,
  input  logic                seq_end_i,
  input  logic                seq_cont_i,
  input  logic                seq_write_i,
  input  logic [LEN_W-1:0]    seq_req_words_i,
  input  logic [LEN_W-1:0]    seq_done_words_i,
  input  logic                rf_fetch_i,
  input  logic                rf_first_i,
  input  logic [RCNT_W-1:0]   rf_count_i,
  input  logic                wf_push_i,
  input  logic [WCNT_W-1:0]   wf_count_i,
  input  logic                int_rd_err_i,
  input  logic                int_wr_err_i,
  input  logic                err_log_wr_i,
  output logic [STICKY_W-1:0] set_o
);
  localparam logic [WCNT_W-1:0] WF_FULL = WCNT_W'(WF_DEPTH);

  logic short_seq, extra_clk, rf_dry, partial_byte;
  logic unused_bits;
  assign unused_bits = ^xfer_bits_i;

  assign partial_byte = (xfer_bits_i[2:0] != 3'd0);
  assign short_seq    = seq_end_i  && (seq_done_words_i <  seq_req_words_i);
  assign extra_clk    = seq_cont_i && (seq_done_words_i >= seq_req_words_i);
  assign rf_dry       = rf_fetch_i && (rf_count_i == '0);

  always_comb begin
    set_o             = '0;
    set_o[B_XFER_END] = xfer_end_i && partial_byte;
    set_o[B_BAD_CMD]  = cmd_valid_i && (cmd_opcode_i != OPC_RD) && (cmd_opcode_i != OPC_WR);
    set_o[B_WR_UNDER] = short_seq &&  seq_write_i;
    set_o[B_RD_UNDER] = short_seq && !seq_write_i;
    set_o[B_WR_OVER]  = extra_clk &&  seq_write_i;
    set_o[B_RD_OVER]  = extra_clk && !seq_write_i;
    set_o[B_RF_EMPTY] = rf_dry &&  rf_first_i;
    set_o[B_RF_UNDER] = rf_dry && !rf_first_i;
    set_o[B_WF_OVF]   = wf_push_i && (wf_count_i >= WF_FULL);
    set_o[B_LOG_WR]   = err_log_wr_i;
    set_o[B_INT_WR]   = int_wr_err_i;
    set_o[B_INT_RD]   = int_rd_err_i;
  end

  AST_BYTE_ALIGNED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_end_i && xfer_bits_i[2:0] == 3'd0) |-> !set_o[B_XFER_END]); // R3
  AST_RF_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_o[B_RF_EMPTY], set_o[B_RF_UNDER]})); // R7
  AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_o[B_WR_UNDER], set_o[B_RD_UNDER], set_o[B_WR_OVER], set_o[B_RD_OVER]})); // R6
endmodule

// File: rtl/spi_err_flags.sv
module spi_err_flags
  import spi_err_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STICKY_W-1:0] set_i,
  input  logic [STICKY_W-1:0] clr_i,
  input  logic [STICKY_W-1:0] mask_i,
  output logic [STICKY_W-1:0] st_o,
  output logic                spi_sum_o,
  output logic                int_sum_o
);
  logic [STICKY_W-1:0] st_q, live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= ((st_q & ~clr_i) | set_i) & VALID_MSK;
  end

  assign live      = st_q & ~mask_i;
  assign spi_sum_o = |(live & SPI_GRP);
  assign int_sum_o = |(live & INT_GRP);
  assign st_o      = st_q;

  AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((st_q & $past(set_i)) == $past(set_i))); // R2
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (|(st_q & ~clr_i)) |=> ((st_q & $past(st_q & ~clr_i)) == $past(st_q & ~clr_i))); // R2
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i & st_q)) |=> ((st_q & $past(clr_i & ~set_i)) == '0)); // R2
  AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_q & ~$past(st_q) & ~$past(set_i)) == '0)); // R2
endmodule

// File: rtl/spi_err_level.sv
module spi_err_level #(
  parameter int WF_DEPTH = 16,
  parameter int WCNT_W   = 5,
  parameter int RCNT_W   = 5
) (
  input  logic [WCNT_W-1:0] wf_count_i,
  input  logic [RCNT_W-1:0] rf_count_i,
  input  logic [WCNT_W-1:0] wr_thr_i,
  input  logic [RCNT_W-1:0] rd_thr_i,
  output logic              wr_avail_o,
  output logic              rd_avail_o
);
  localparam logic [WCNT_W-1:0] WF_FULL = WCNT_W'(WF_DEPTH);
  logic [WCNT_W-1:0] wf_free;

  assign wf_free    = (wf_count_i >= WF_FULL) ? '0 : (WF_FULL - wf_count_i);
  assign wr_avail_o = (wf_free >= wr_thr_i);
  assign rd_avail_o = (rf_count_i >= rd_thr_i);

  always_comb begin
    if (rd_thr_i == '0) AST_RD_ZERO_THR: assert (rd_avail_o); // R10
    if (wr_thr_i == '0) AST_WR_ZERO_THR: assert (wr_avail_o); // R10
  end
endmodule

// File: rtl/spi_err_regs.sv
module spi_err_regs
  import spi_err_pkg::*;
#(
  parameter int WCNT_W = 5,
  parameter int RCNT_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  input  logic [STICKY_W-1:0] st_i,
  input  logic                wr_avail_i,
  input  logic                rd_avail_i,
  input  logic                spi_sum_i,
  input  logic                int_sum_i,
  input  logic                irq_i,
  output logic [STICKY_W-1:0] clr_o,
  output logic [STICKY_W-1:0] mask_o,
  output logic [WCNT_W-1:0]   wr_thr_o,
  output logic [RCNT_W-1:0]   rd_thr_o,
  output logic [31:0]         rdata_o
);
  reg_addr_e addr;
  logic unused_wdata;
  assign addr         = reg_addr_e'(reg_addr_i);
  assign unused_wdata = ^reg_wdata_i;

  assign clr_o = (reg_wr_i && addr == A_STATUS) ? (reg_wdata_i[STICKY_W-1:0] & VALID_MSK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o   <= '0;
      wr_thr_o <= WCNT_W'(1);
      rd_thr_o <= RCNT_W'(1);
    end else if (reg_wr_i) begin
      if (addr == A_MASK) mask_o <= reg_wdata_i[STICKY_W-1:0] & VALID_MSK;
      if (addr == A_THRESH) begin
        wr_thr_o <= reg_wdata_i[WCNT_W-1:0];
        rd_thr_o <= reg_wdata_i[8 +: RCNT_W];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      A_STATUS: begin
        rdata_o[STICKY_W-1:0] = st_i;
        rdata_o[B_WR_AVAIL]   = wr_avail_i;
        rdata_o[B_RD_AVAIL]   = rd_avail_i;
        rdata_o[B_SPI_SUM]    = spi_sum_i;
        rdata_o[B_INT_SUM]    = int_sum_i;
        rdata_o[B_IRQ]        = irq_i;
      end
      A_MASK:   rdata_o[STICKY_W-1:0] = mask_o;
      A_THRESH: begin
        rdata_o[WCNT_W-1:0] = wr_thr_o;
        rdata_o[8 +: RCNT_W] = rd_thr_o;
      end
      default:  rdata_o = '0;
    endcase
  end

  AST_MASK_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o & ~VALID_MSK) == '0); // R12
endmodule

// File: rtl/spi_err_status.sv
module spi_err_status
  import spi_err_pkg::*;
#(
  parameter int BITCNT_W = 16,
  parameter int LEN_W    = 8,
  parameter int WF_DEPTH = 16,
  parameter int RF_DEPTH = 16,
  parameter logic [7:0] OPC_RD = 8'h41,
  parameter logic [7:0] OPC_WR = 8'h61,
  localparam int WCNT_W = $clog2(WF_DEPTH + 1),
  localparam int RCNT_W = $clog2(RF_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xfer_end_i,
  input  logic [BITCNT_W-1:0] xfer_bits_i,
  input  logic                cmd_valid_i,
  input  logic [7:0]          cmd_opcode_i,
  input  logic                seq_end_i,
  input  logic                seq_cont_i,
  input  logic                seq_write_i,
  input  logic [LEN_W-1:0]    seq_req_words_i,
  input  logic [LEN_W-1:0]    seq_done_words_i,
  input  logic                rf_fetch_i,
  input  logic                rf_first_i,
  input  logic [RCNT_W-1:0]   rf_count_i,
  input  logic                wf_push_i,
  input  logic [WCNT_W-1:0]   wf_count_i,
  input  logic                int_rd_err_i,
  input  logic                int_wr_err_i,
  input  logic                err_log_wr_i,
  input  logic                reg_wr_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                wr_avail_o,
  output logic                rd_avail_o,
  output logic                spi_err_irq_o,
  output logic                int_err_irq_o,
  output logic                irq_o
);
  logic [STICKY_W-1:0] set_vec, clr_vec, mask_q, st_q;
  logic [WCNT_W-1:0]   wr_thr;
  logic [RCNT_W-1:0]   rd_thr;

  spi_err_detect #(
    .BITCNT_W(BITCNT_W), .LEN_W(LEN_W), .WF_DEPTH(WF_DEPTH),
    .WCNT_W(WCNT_W), .RCNT_W(RCNT_W), .OPC_RD(OPC_RD), .OPC_WR(OPC_WR)
  ) i_detect (
    .clk(clk), .rst_n(rst_n),
    .xfer_end_i(xfer_end_i), .xfer_bits_i(xfer_bits_i),
    .cmd_valid_i(cmd_valid_i), .cmd_opcode_i(cmd_opcode_i),
    .seq_end_i(seq_end_i), .seq_cont_i(seq_cont_i), .seq_write_i(seq_write_i),
    .seq_req_words_i(seq_req_words_i), .seq_done_words_i(seq_done_words_i),
    .rf_fetch_i(rf_fetch_i), .rf_first_i(rf_first_i), .rf_count_i(rf_count_i),
    .wf_push_i(wf_push_i), .wf_count_i(wf_count_i),
    .int_rd_err_i(int_rd_err_i), .int_wr_err_i(int_wr_err_i), .err_log_wr_i(err_log_wr_i),
    .set_o(set_vec)
  );

  spi_err_flags i_flags (
    .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .mask_i(mask_q),
    .st_o(st_q), .spi_sum_o(spi_err_irq_o), .int_sum_o(int_err_irq_o)
  );

  assign irq_o = spi_err_irq_o | int_err_irq_o;

  spi_err_level #(.WF_DEPTH(WF_DEPTH), .WCNT_W(WCNT_W), .RCNT_W(RCNT_W)) i_level (
    .wf_count_i(wf_count_i), .rf_count_i(rf_count_i),
    .wr_thr_i(wr_thr), .rd_thr_i(rd_thr),
    .wr_avail_o(wr_avail_o), .rd_avail_o(rd_avail_o)
  );

  spi_err_regs #(.WCNT_W(WCNT_W), .RCNT_W(RCNT_W)) i_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .st_i(st_q), .wr_avail_i(wr_avail_o), .rd_avail_i(rd_avail_o),
    .spi_sum_i(spi_err_irq_o), .int_sum_i(int_err_irq_o), .irq_i(irq_o),
    .clr_o(clr_vec), .mask_o(mask_q), .wr_thr_o(wr_thr), .rd_thr_o(rd_thr),
    .rdata_o(reg_rdata_o)
  );

  AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == '0) |-> !irq_o); // R11
  AST_IRQ_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(st_q & ~mask_q))); // R11
endmodule

// File: tb/test_spi_err_status.sv
module test_spi_err_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        xfer_end = 0;  logic [15:0] xfer_bits = 0;
  logic        cmd_valid = 0; logic [7:0]  cmd_op = 0;
  logic        seq_end = 0, seq_cont = 0, seq_wr = 0;
  logic [7:0]  req_w = 0, done_w = 0;
  logic        rf_fetch = 0, rf_first = 0; logic [4:0] rf_cnt = 0;
  logic        wf_push = 0; logic [4:0] wf_cnt = 0;
  logic        i_rd = 0, i_wr = 0, i_log = 0;
  logic        reg_wr = 0; logic [1:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] rdata;
  logic        wr_av, rd_av, spi_irq, int_irq, irq;

  spi_err_status i_spi_err_status (
    .clk(clk), .rst_n(rst_n),
    .xfer_end_i(xfer_end), .xfer_bits_i(xfer_bits),
    .cmd_valid_i(cmd_valid), .cmd_opcode_i(cmd_op),
    .seq_end_i(seq_end), .seq_cont_i(seq_cont), .seq_write_i(seq_wr),
    .seq_req_words_i(req_w), .seq_done_words_i(done_w),
    .rf_fetch_i(rf_fetch), .rf_first_i(rf_first), .rf_count_i(rf_cnt),
    .wf_push_i(wf_push), .wf_count_i(wf_cnt),
    .int_rd_err_i(i_rd), .int_wr_err_i(i_wr), .err_log_wr_i(i_log),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(rdata), .wr_avail_o(wr_av), .rd_avail_o(rd_av),
    .spi_err_irq_o(spi_irq), .int_err_irq_o(int_irq), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0, cyc = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_st = 0, m_mask = 0, m_wthr = 1, m_rthr = 1;

  always @(posedge clk) begin
    int s;
    if (!rst_n) begin
      m_st = 0; m_mask = 0; m_wthr = 1; m_rthr = 1;
    end else begin
      s = 0;
      if (xfer_end && (int'(xfer_bits) % 8) != 0) s |= 1 << 0;
      if (cmd_valid && cmd_op != 8'h41 && cmd_op != 8'h61) s |= 1 << 1;
      if (seq_end && int'(done_w) < int'(req_w)) s |= seq_wr ? (1 << 2) : (1 << 4);
      if (seq_cont && int'(done_w) >= int'(req_w)) s |= seq_wr ? (1 << 3) : (1 << 5);
      if (rf_fetch && rf_cnt == 0) s |= rf_first ? (1 << 9) : (1 << 10);
      if (wf_push && int'(wf_cnt) == 16) s |= 1 << 8;
      if (i_log) s |= 1 << 11;
      if (i_wr)  s |= 1 << 12;
      if (i_rd)  s |= 1 << 13;
      if (reg_wr && reg_addr == 2'd0) m_st &= ~int'(reg_wdata & 32'h3F3F);
      m_st |= s;
      if (reg_wr && reg_addr == 2'd1) m_mask = int'(reg_wdata & 32'h3F3F);
      if (reg_wr && reg_addr == 2'd2) begin
        m_wthr = int'(reg_wdata[4:0]);
        m_rthr = int'(reg_wdata[12:8]);
      end
    end
  end

  function automatic int m_wa(); return ((16 - int'(wf_cnt)) >= m_wthr) ? 1 : 0; endfunction
  function automatic int m_ra(); return (int'(rf_cnt) >= m_rthr) ? 1 : 0; endfunction
  function automatic int m_spi(); return ((m_st & ~m_mask & 32'h073F) != 0) ? 1 : 0; endfunction
  function automatic int m_int(); return ((m_st & ~m_mask & 32'h3800) != 0) ? 1 : 0; endfunction
  function automatic logic [31:0] m_rd();
    int irqv;
    irqv = m_spi() | m_int();
    case (reg_addr)
      2'd0: return 32'(m_st | (m_wa() << 16) | (m_ra() << 17) | (m_spi() << 24) | (m_int() << 25) | (irqv << 26));
      2'd1: return 32'(m_mask);
      2'd2: return 32'(m_wthr | (m_rthr << 8));
      default: return 32'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    #4;
    if (rst_n) begin
      chk("R10 wr_avail model", {31'd0, wr_av}, 32'(m_wa()));
      chk("R10 rd_avail model", {31'd0, rd_av}, 32'(m_ra()));
      chk("R11 spi_err_irq model", {31'd0, spi_irq}, 32'(m_spi()));
      chk("R11 int_err_irq model", {31'd0, int_irq}, 32'(m_int()));
      chk("R11 irq model", {31'd0, irq}, 32'(m_spi() | m_int()));
      chk("R2 R12 rdata model", rdata, m_rd());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    xfer_end = 0; cmd_valid = 0; seq_end = 0; seq_cont = 0; rf_fetch = 0;
    wf_push = 0; i_rd = 0; i_wr = 0; i_log = 0; reg_wr = 0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick();
  endtask

  task automatic st_is(input logic [13:0] exp, input string tag);
    reg_addr = 2'd0; #2;
    chk(tag, {18'd0, rdata[13:0]}, {18'd0, exp});
  endtask

  task automatic clr_all(); wreg(2'd0, 32'hFFFF_FFFF); st_is(14'h0, "R2 clear all"); endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1 reset status", rdata, 32'h0001_0000);
    chk("R1 reset irq", {29'd0, spi_irq, int_irq, irq}, 32'h0);
    rst_n = 1;
    tick();
    reg_addr = 2'd1; #2; chk("R1 reset mask", rdata, 32'h0);
    reg_addr = 2'd2; #2; chk("R1 reset thresholds", rdata, 32'h0000_0101);

    // R3 transfer end
    xfer_end = 1; xfer_bits = 16; tick(); st_is(14'h0, "R3 aligned end");
    xfer_end = 1; xfer_bits = 13; tick(); st_is(14'h0001, "R3 partial byte");
    wreg(2'd0, 32'h0); st_is(14'h0001, "R2 write zero no effect");
    wreg(2'd0, 32'h1); st_is(14'h0, "R2 w1c clears");

    // R4 command decode
    cmd_valid = 1; cmd_op = 8'h41; tick();
    cmd_valid = 1; cmd_op = 8'h61; tick(); st_is(14'h0, "R4 supported opcodes");
    cmd_valid = 1; cmd_op = 8'h00; tick(); st_is(14'h0002, "R4 bad opcode");
    clr_all();

    // R5 underflow
    seq_end = 1; seq_wr = 1; req_w = 4; done_w = 4; tick(); st_is(14'h0, "R5 complete seq");
    seq_end = 1; seq_wr = 1; done_w = 3; tick(); st_is(14'h0004, "R5 write underflow");
    seq_end = 1; seq_wr = 0; tick(); st_is(14'h0014, "R5 read underflow");
    clr_all();

    // R6 overflow
    seq_cont = 1; seq_wr = 1; req_w = 2; done_w = 1; tick(); st_is(14'h0, "R6 cont in range");
    seq_cont = 1; done_w = 2; tick(); st_is(14'h0008, "R6 write overflow");
    seq_cont = 1; seq_wr = 0; done_w = 3; tick(); st_is(14'h0028, "R6 read overflow");
    clr_all();

    // R7 read FIFO
    rf_fetch = 1; rf_first = 1; rf_cnt = 3; tick(); st_is(14'h0, "R7 fifo has data");
    rf_fetch = 1; rf_cnt = 0; tick(); st_is(14'h0200, "R7 empty on first");
    rf_fetch = 1; rf_first = 0; tick(); st_is(14'h0600, "R7 later underflow");
    clr_all();

    // R8 write FIFO overflow
    wf_push = 1; wf_cnt = 15; tick(); st_is(14'h0, "R8 room left");
    wf_push = 1; wf_cnt = 16; tick(); st_is(14'h0100, "R8 push when full");
    wf_cnt = 0;
    clr_all();

    // R9 internal strobes
    i_log = 1; tick(); st_is(14'h0800, "R9 log write");
    i_wr = 1; tick(); i_rd = 1; tick(); st_is(14'h3800, "R9 internal errors");
    clr_all();

    // R2 set and clear same cycle
    i_rd = 1; reg_wr = 1; reg_addr = 2'd0; reg_wdata = 32'h2000; tick();
    st_is(14'h2000, "R2 set wins over clear");
    clr_all();

    // R11 summaries and masking
    xfer_end = 1; xfer_bits = 7; tick(); #2;
    chk("R11 spi summary", {29'd0, spi_irq, int_irq, irq}, 32'h5);
    reg_addr = 2'd0; #1; chk("R11 summary bits", {29'd0, rdata[26:24]}, 32'h5);
    wreg(2'd1, 32'h1); #2;
    chk("R11 masked spi", {29'd0, spi_irq, int_irq, irq}, 32'h0);
    st_is(14'h0001, "R11 masked bit still readable");
    i_wr = 1; tick(); #2;
    chk("R11 internal summary", {29'd0, spi_irq, int_irq, irq}, 32'h3);
    wreg(2'd1, 32'h0); clr_all();

    // R10 thresholds
    wreg(2'd2, 32'h0000_0304);
    rf_cnt = 2; wf_cnt = 12; #2;
    chk("R10 rd below", {31'd0, rd_av}, 32'h0);
    chk("R10 wr free equal", {31'd0, wr_av}, 32'h1);
    rf_cnt = 3; wf_cnt = 13; #2;
    chk("R10 rd equal", {31'd0, rd_av}, 32'h1);
    chk("R10 wr free below", {31'd0, wr_av}, 32'h0);
    reg_addr = 2'd0; #1; chk("R10 status level bits", {30'd0, rdata[17:16]}, 32'h2);
    tick(); rf_cnt = 0; wf_cnt = 0;

    // R12 reserved
    wreg(2'd1, 32'hFFFF_FFFF); reg_addr = 2'd1; #2;
    chk("R12 mask writable bits", rdata, 32'h0000_3F3F);
    wreg(2'd1, 32'h0);
    wreg(2'd3, 32'hFFFF_FFFF); reg_addr = 2'd3; #2; chk("R12 unused address", rdata, 32'h0);
    xfer_end = 1; cmd_valid = 1; cmd_op = 8'h12; seq_end = 1; seq_wr = 1; req_w = 5; done_w = 1;
    rf_fetch = 1; rf_first = 1; wf_push = 1; wf_cnt = 16; i_rd = 1; i_wr = 1; i_log = 1; tick();
    wf_cnt = 0; reg_addr = 2'd0; #2;
    chk("R12 reserved status bits", rdata & 32'hF8FC_C0C0, 32'h0);
    clr_all();

    // mixed stimulus against the model
    for (int k = 0; k < 400; k++) begin
      xfer_end = ($urandom % 6) == 0; xfer_bits = 16'($urandom % 40);
      cmd_valid = ($urandom % 5) == 0; cmd_op = (($urandom % 2) == 0) ? 8'h41 : 8'($urandom);
      seq_end = ($urandom % 6) == 0; seq_cont = ($urandom % 6) == 0; seq_wr = 1'($urandom);
      req_w = 8'($urandom % 5); done_w = 8'($urandom % 5);
      rf_fetch = ($urandom % 5) == 0; rf_first = 1'($urandom); rf_cnt = 5'($urandom % 4);
      wf_push = ($urandom % 4) == 0; wf_cnt = 5'(13 + $urandom % 4);
      i_rd = ($urandom % 9) == 0; i_wr = ($urandom % 9) == 0; i_log = ($urandom % 9) == 0;
      reg_wr = ($urandom % 4) == 0; reg_addr = 2'($urandom); reg_wdata = $urandom;
      tick();
      reg_addr = 2'($urandom);
    end
    tick(); tick();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule